// File: doc/BRIEF.md
# SPI Master Serial Clock Generator

This block derives the serial clock of an SPI master from a faster reference clock. A 3-bit exponent code picks a power-of-two divide ratio between 4 and 256. A polarity input sets the level the serial clock rests at between transfers. A phase input decides whether the leading or the trailing edge of each period is the one where data is sampled. The other edge of each period is the one where the next bit is launched.

A shift engine requests a transfer with a one-cycle `start` pulse. The generator then raises `busy` and the slave-select enable together. It waits one half-period, then produces a fixed number of serial clock periods (parameter `PERIODS`). It waits one more half-period with the clock back at its resting level, and then drops `busy`. Alongside the clock it emits one-reference-cycle strobes that tell the shift engine when to sample and when to launch. Each strobe is high in the cycle in which the serial clock output first shows the corresponding edge.

The divider code and the mode bits are captured only while the generator is idle. Once a transfer runs, its clock cannot be stretched, shortened or glitched by register writes.

Top module: `spi_sclk_gen`

## Requirements
- R1: For codes 1 to 7 the serial clock period is 2^(code+1) reference cycles, and each half-period is 2^code cycles.
- R2: Code 0 gives the same timing as code 1, a period of 4 reference cycles.
- R3: While idle, `sclk` equals the `cpol` value sampled at the previous clock edge. After a transfer, `sclk` rests at the polarity that was captured for that transfer.
- R4: With `cpha`=0, `sampleStb` marks every leading edge (the first edge, which leaves the resting level). `launchStb` marks the start of the transfer and every trailing edge except the last. With `cpha`=1, `launchStb` marks every leading edge and `sampleStb` marks every trailing edge.
- R5: Each strobe is high for exactly one reference cycle: the first cycle in which `sclk` shows its new level, or the acceptance cycle for the initial launch. `sampleStb` and `launchStb` are never high together.
- R6: `busy` and `ssActive` rise in the cycle after `start` is accepted. The first `sclk` edge follows exactly one half-period later.
- R7: A transfer contains exactly `PERIODS` serial clock periods (2*`PERIODS` edges). `busy` and `ssActive` fall one half-period after the last edge. Reset leaves every output low.
- R8: Changes to `divCode`, `cpol` or `cpha` while `busy` is high do not alter the running transfer.
- R9: `start` is accepted only while idle and with `enable` high. Otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows new transfers to be accepted |
| start | input | 1 | One-cycle transfer request from the shift engine |
| divCode | input | CODE_W | Exponent code for the divide ratio |
| cpol | input | 1 | Resting level of the serial clock |
| cpha | input | 1 | 0: sample on leading edges; 1: sample on trailing edges |
| sclk | output | 1 | Serial clock |
| sampleStb | output | 1 | One-cycle strobe at each sample edge |
| launchStb | output | 1 | One-cycle strobe at each launch point |
| ssActive | output | 1 | Slave-select enable, high for the whole transfer |
| busy | output | 1 | High from acceptance until the closing half-period ends |

## Verification
The assertions assume that reset is asserted before the first clock edge and that all inputs are synchronous to `clk`. They let `start` arrive at any time, including while a transfer runs. Only a request that meets an idle generator is expected to start a transfer. The bench changes every input on the falling edge, so each value is stable at the rising edge that samples it. It deliberately flips the divider code and both mode bits in the middle of a transfer, and it pulses `start` while busy, to show that these inputs are tolerated without effect. Before each transfer the bench holds `enable` high for at least one idle cycle, with one exception: a dedicated case raises `start` with `enable` low.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_TAIL   = 2'd2
  } genState_t;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic loadIdle;    // hold sclk at the resting level
    logic idleLevel;   // resting level to load
    logic restart;     // clear the half-period and edge counters
    logic count;       // advance the half-period counter
    logic toggle;      // flip sclk and issue an edge strobe
    logic initLaunch;  // launch strobe at acceptance (phase 0)
  } sclkCtrl_t;

  // Status from the datapath back to the control FSM.
  typedef struct packed {
    logic halfDone;    // current half-period ends this cycle
    logic lastEdge;    // the pending edge is the final one
  } sclkStat_t;

endpackage

// File: rtl/sclk_ctrl.sv
module sclk_ctrl
  import spi_sclk_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              start,
  input  logic [CODE_W-1:0] divCode,
  input  logic              cpolIn,
  input  logic              cphaIn,
  input  sclkStat_t         stat,
  output sclkCtrl_t         ctrl,
  output logic              busy,
  output logic              cfgPol,
  output logic              cfgPha,
  output logic [CNT_W-1:0]  halfLast
);

  genState_t         state;
  genState_t         stateNxt;
  logic [CODE_W-1:0] cfgCode;
  logic [CODE_W-1:0] codeEff;
  logic              accept;

  assign accept = (state == ST_IDLE) && enable && start;
  assign busy   = (state != ST_IDLE);

  // Code 0 is below the legal minimum ratio and is raised to code 1.
  assign codeEff  = (cfgCode == '0) ? CODE_W'(1) : cfgCode;
  assign halfLast = CNT_W'((32'd1 << codeEff) - 32'd1);

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:   if (accept) stateNxt = ST_ACTIVE;
      ST_ACTIVE: if (stat.halfDone && stat.lastEdge) stateNxt = ST_TAIL;
      ST_TAIL:   if (stat.halfDone) stateNxt = ST_IDLE;
      default:   stateNxt = ST_IDLE;
    endcase
  end

  always_comb begin
    ctrl            = '0;
    ctrl.loadIdle   = (state == ST_IDLE);
    ctrl.idleLevel  = cpolIn;
    ctrl.restart    = accept;
    ctrl.count      = (state != ST_IDLE);
    ctrl.toggle     = (state == ST_ACTIVE) && stat.halfDone;
    ctrl.initLaunch = accept && !cphaIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cfgCode <= '0;
      cfgPol  <= 1'b0;
      cfgPha  <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == ST_IDLE) begin
        cfgCode <= divCode;
        cfgPol  <= cpolIn;
        cfgPha  <= cphaIn;
      end
    end
  end

  // R8: configuration is frozen for the whole transfer
  assert_cfg_frozen_R8 : assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(cfgCode) && $stable(cfgPol) && $stable(cfgPha)));

  // R9: a transfer only begins from an enabled request
  assert_accept_gated_R9 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start && enable));

  // R2: the half-period is never shorter than two reference cycles
  assert_min_ratio_R2 : assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (halfLast >= CNT_W'(1)));

endmodule

// File: rtl/sclk_dp.sv
module sclk_dp
  import spi_sclk_pkg::*;
#(
  parameter int CNT_W     = 7,
  parameter int NUM_EDGES = 16,
  parameter int EDGE_W    = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  sclkCtrl_t        ctrl,
  input  logic [CNT_W-1:0] halfLast,
  input  logic             cfgPha,
  output sclkStat_t        stat,
  output logic             sclk,
  output logic             sampleStb,
  output logic             launchStb
);

  logic [CNT_W-1:0]  halfCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic [EDGE_W-1:0] edgeIdx;
  logic              leading;

  assign edgeIdx       = edgeCnt + EDGE_W'(1);
  assign leading       = edgeIdx[0];
  assign stat.halfDone = (halfCnt == halfLast);
  assign stat.lastEdge = (edgeIdx == EDGE_W'(NUM_EDGES));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfCnt <= '0;
    end else if (ctrl.restart) begin
      halfCnt <= '0;
    end else if (ctrl.count) begin
      halfCnt <= stat.halfDone ? '0 : halfCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt <= '0;
    end else if (ctrl.restart) begin
      edgeCnt <= '0;
    end else if (ctrl.toggle) begin
      edgeCnt <= edgeIdx;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclk <= 1'b0;
    end else if (ctrl.loadIdle) begin
      sclk <= ctrl.idleLevel;
    end else if (ctrl.toggle) begin
      sclk <= ~sclk;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleStb <= 1'b0;
      launchStb <= 1'b0;
    end else begin
      sampleStb <= 1'b0;
      launchStb <= ctrl.initLaunch;
      if (ctrl.toggle) begin
        sampleStb <= leading ^ cfgPha;
        launchStb <= cfgPha ? leading : (!leading && !stat.lastEdge);
      end
    end
  end

  // R1: half-period counter stays inside the programmed window
  assert_no_overflow_R1 : assert property (@(posedge clk) disable iff (!rstN)
    ctrl.count |-> (halfCnt <= halfLast));

  // R5: strobes are mutually exclusive
  assert_stb_exclusive_R5 : assert property (@(posedge clk) disable iff (!rstN)
    !(sampleStb && launchStb));

  // R5: a sample strobe coincides with a fresh sclk level
  assert_sample_on_edge_R5 : assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |-> (sclk != $past(sclk)));

  // R7: never more edges than a transfer holds
  assert_edge_bound_R7 : assert property (@(posedge clk) disable iff (!rstN)
    edgeCnt <= EDGE_W'(NUM_EDGES));

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import spi_sclk_pkg::*;
#(
  parameter int CODE_W  = 3,
  parameter int PERIODS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              start,
  input  logic [CODE_W-1:0] divCode,
  input  logic              cpol,
  input  logic              cpha,
  output logic              sclk,
  output logic              sampleStb,
  output logic              launchStb,
  output logic              ssActive,
  output logic              busy
);

  localparam int CNT_W     = (1 << CODE_W) - 1;
  localparam int NUM_EDGES = 2 * PERIODS;
  localparam int EDGE_W    = $clog2(NUM_EDGES + 1);

  sclkCtrl_t        ctrl;
  sclkStat_t        stat;
  logic [CNT_W-1:0] halfLast;
  logic             cfgPol;
  logic             cfgPha;
  logic             busyInt;

  sclk_ctrl #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .start    (start),
    .divCode  (divCode),
    .cpolIn   (cpol),
    .cphaIn   (cpha),
    .stat     (stat),
    .ctrl     (ctrl),
    .busy     (busyInt),
    .cfgPol   (cfgPol),
    .cfgPha   (cfgPha),
    .halfLast (halfLast)
  );

  sclk_dp #(.CNT_W(CNT_W), .NUM_EDGES(NUM_EDGES), .EDGE_W(EDGE_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .halfLast  (halfLast),
    .cfgPha    (cfgPha),
    .stat      (stat),
    .sclk      (sclk),
    .sampleStb (sampleStb),
    .launchStb (launchStb)
  );

  assign busy     = busyInt;
  assign ssActive = busyInt;

  // R3: resting level tracks polarity while idle
  assert_idle_level_R3 : assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy)) |-> (sclk == $past(cpol)));

  // R7: transfer ends with the clock at its captured resting level
  assert_tail_idle_R7 : assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (sclk == cfgPol));

  // R6: no edge strobe in the first busy cycle besides the initial launch
  assert_ss_lead_R6 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(ssActive) |-> !sampleStb);

endmodule

// File: tb/sim_spi_sclk_gen.sv
module sim_spi_sclk_gen;

  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       start = 1'b0;
  logic [2:0] divCode = 3'd1;
  logic       cpol = 1'b0;
  logic       cpha = 1'b0;
  logic       sclk, sampleStb, launchStb, ssActive, busy;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #4 clk = ~clk;

  spi_sclk_gen #(.CODE_W(3), .PERIODS(N)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .start(start),
    .divCode(divCode), .cpol(cpol), .cpha(cpha),
    .sclk(sclk), .sampleStb(sampleStb), .launchStb(launchStb),
    .ssActive(ssActive), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  bit mBusy, mSclk, mS, mL, mPha;
  int mT, mH;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mSclk = 0; mS = 0; mL = 0; mT = 0; mH = 2;
    end else if (!mBusy) begin
      mS = 0; mL = 0; mSclk = cpol;
      if (enable && start) begin
        mBusy = 1; mT = 0;
        mH = 1 << ((divCode == 0) ? 1 : int'(divCode));
        mPha = cpha; mL = !cpha;
      end
    end else begin
      mS = 0; mL = 0; mT++;
      if (mT % mH == 0) begin
        int k;
        bit lead;
        k = mT / mH;
        if (k <= 2 * N) begin
          mSclk = !mSclk;
          lead = (k % 2) == 1;
          mS = mPha ? !lead : lead;
          mL = mPha ? lead : (!lead && k < 2 * N);
        end else begin
          mBusy = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk(busy == mBusy, "R7 busy", busy, mBusy);
      chk(ssActive == mBusy, "R6 ssActive", ssActive, mBusy);
      chk(sclk == mSclk, "R3 sclk", sclk, mSclk);
      chk(sampleStb == mS, "R4 sampleStb", sampleStb, mS);
      chk(launchStb == mL, "R5 launchStb", launchStb, mL);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  task automatic doXfer(input int code, input bit pol, input bit pha, input bit mutate);
    int cyc, first, lastS, per, nS, h;
    bit prev;
    string tagP;
    h = 1 << ((code == 0) ? 1 : code);
    @(negedge clk);
    divCode = 3'(code); cpol = pol; cpha = pha; enable = 1;
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    cyc = 0; first = -1; lastS = -1; per = -1; nS = 0; prev = sclk;
    while (busy && cyc < 5000) begin
      if (mutate && cyc == 3) begin
        divCode = ~divCode; cpol = ~cpol; cpha = ~cpha; start = 1;
      end
      if (mutate && cyc == 4) start = 0;
      if (sclk != prev && first < 0) first = cyc;
      prev = sclk;
      if (sampleStb) begin
        nS++;
        if (lastS >= 0) per = cyc - lastS;
        lastS = cyc;
      end
      @(negedge clk);
      cyc++;
    end
    start = 0;
    tagP = mutate ? "R8 period" : ((code == 0) ? "R2 period" : "R1 period");
    chk(first == h, "R6 lead half-period", first, h);
    chk(nS == N, "R7 sample count", nS, N);
    chk(per == 2 * h, tagP, per, 2 * h);
    chk(cyc == (2 * N + 1) * h, "R7 transfer length", cyc, (2 * N + 1) * h);
    chk(sclk == pol, "R3 resting level", sclk, pol);
    @(negedge clk);
    divCode = 3'(code); cpol = pol; cpha = pha;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && sclk == 0 && sampleStb == 0 && launchStb == 0 && ssActive == 0,
        "R7 reset state", {busy, sclk, sampleStb, launchStb, ssActive}, 0);
    rstN = 1;
    // idle polarity following
    repeat (2) @(negedge clk);
    cpol = 1;
    repeat (3) @(negedge clk);
    chk(sclk == 1, "R3 idle follows cpol", sclk, 1);
    cpol = 0;
    repeat (2) @(negedge clk);
    // R9: request with enable low is ignored
    enable = 0; start = 1;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    chk(busy == 0, "R9 enable low ignored", busy, 0);
    // R1 / R4: each code across the four modes
    for (int c = 1; c < 8; c++) begin
      doXfer(c, c[0], c[1], 0);
    end
    doXfer(1, 0, 0, 0);
    doXfer(2, 1, 1, 0);
    // R2: code zero
    doXfer(0, 0, 1, 0);
    doXfer(0, 1, 0, 0);
    // R8, R9: config flips and start during busy
    doXfer(2, 0, 0, 1);
    doXfer(3, 1, 1, 1);
    // back-to-back requests with start held high
    enable = 1; divCode = 3'd1; cpol = 0; cpha = 1; start = 1;
    repeat (2 * (2 * N + 1) * 2 + 6) @(negedge clk);
    start = 0;
    repeat (60) @(negedge clk);
    chk(busy == 0, "R7 idle after back-to-back", busy, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule